// File: doc/BRIEF.md
# Bit-Serial Adder with Unfolded Parallel Form

The block adds two 4-bit unsigned words in two equivalent ways that share one clock and one reset. The serial path accepts one bit of each operand per clock, least significant bit first, and returns one registered sum bit per clock. A single carry flip-flop closes the loop around a full adder. A periodic switch replaces the fed-back carry with zero in the first bit slot of every word, so a carry never leaks from one word into the next.

The parallel path is the same graph unfolded by the word length. The four time slots of the serial loop become four full-adder stages. The carry register becomes a wire from stage i to stage i+1, and the slot-0 switch becomes a constant zero carry into stage 0. That path adds a whole word every clock and registers the result. Both forms wrap modulo 16 and discard the final carry.

A word-start marker that comes with bit 0 aligns the serial slot counter. Without a marker, the counter runs freely and returns to slot 0 every four clocks, so back-to-back words need only the first marker.

Top module: `bit_serial_adder_top`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `ser_sum` is 0 and `par_sum` is 4'b0000.
- R2: The serial sum bit for the input bits driven in clock cycle t equals a XOR b XOR carry-in, and it appears on `ser_sum` after the rising edge that ends cycle t.
- R3: In slot 0 the carry-in is zero, whatever carry the previous word left. The word collected from `ser_sum` equals (a+b) mod 16, including after a word that produced a carry out.
- R4: `ser_start` high puts the current input bits in slot 0 even in the middle of a word. Any partial word and its carry are dropped.
- R5: With no `ser_start`, the slot counter wraps from slot 3 to slot 0, so words sent back to back without markers are still summed correctly.
- R6: `par_sum` equals (`par_a` + `par_b`) mod 16 one clock after the operands are applied. The carry out of bit 3 is discarded.
- R7: For the same operand pair, the word assembled from the four serial sum bits equals `par_sum`.
- R8: Serial bits are least significant first: sum bit k leaves `ser_sum` k+1 clocks after bit 0 of the operands is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Serial operand A bit, LSB first |
| ser_b | input | 1 | Serial operand B bit, LSB first |
| ser_start | input | 1 | Marks the current bits as bit 0 of a word |
| ser_sum | output | 1 | Registered serial sum bit |
| par_a | input | 4 | Parallel operand A |
| par_b | input | 4 | Parallel operand B |
| par_sum | output | 4 | Registered parallel sum, mod 16 |

## Verification
The hardest situation to reach is a carry left pending in the flip-flop at a word boundary. It needs a word whose top bit pair generates a carry, followed at once by a word that would be corrupted if that carry leaked in. It also needs an abort in mid-word while a carry is set. Directed cases cover these: 15+15 followed by 0+0, 15+1 followed by 8+8, and a restart after two bits of 15+1. Random words sent back to back, mostly without start markers, then exercise the free-running wrap of the slot counter and compare each serial word with the parallel result and with the expected sum.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int unsigned WORD_W_DEF = 4;

    typedef enum logic [0:0] {
        CARRY_FEEDBACK = 1'b0,
        CARRY_ZERO     = 1'b1
    } carry_sel_e;

    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (ci & (x ^ y));
    endfunction

endpackage

// File: rtl/bsa_slot_ctr.sv
module bsa_slot_ctr #(
    parameter int unsigned WORD_W = bsa_pkg::WORD_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output bsa_pkg::carry_sel_e carry_sel
);
    import bsa_pkg::*;

    localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    logic [CW-1:0] next_q;
    logic [CW-1:0] slot;

    always_comb begin
        slot = start ? '0 : next_q;
        carry_sel = (slot == '0) ? CARRY_ZERO : CARRY_FEEDBACK;
    end

    always_ff @(posedge clk) begin
        if (rst)
            next_q <= '0;
        else if (slot == LAST)
            next_q <= '0;
        else
            next_q <= slot + CW'(1);
    end

    // R4
    start_realign_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (next_q == ((WORD_W > 1) ? CW'(1) : '0)));

    // R5
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && next_q == LAST) |=> (next_q == '0));

endmodule

// File: rtl/bsa_serial_core.sv
module bsa_serial_core (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    input  bsa_pkg::carry_sel_e carry_sel,
    output logic sum_q
);
    import bsa_pkg::*;

    logic carry_q;
    logic cin;

    always_comb begin
        cin = (carry_sel == CARRY_ZERO) ? 1'b0 : carry_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            sum_q   <= 1'b0;
        end else begin
            carry_q <= fa_carry(a, b, cin);
            sum_q   <= fa_sum(a, b, cin);
        end
    end

    // R3
    slot0_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (carry_sel == CARRY_ZERO) |=> (sum_q == $past(a ^ b)));

    // R3
    slot0_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (carry_sel == CARRY_ZERO) |=> (carry_q == $past(a & b)));

endmodule

// File: rtl/bsa_unfolded.sv
module bsa_unfolded #(
    parameter int unsigned WORD_W = bsa_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] sum_q
);
    import bsa_pkg::*;

    logic [WORD_W-1:0] chain;
    logic [WORD_W-1:0] sum_d;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WORD_W; i++) begin : g_stage
        assign sum_d[i] = fa_sum(a[i], b[i], chain[i]);
        if (i < WORD_W - 1) begin : g_ripple
            assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end

    // R6
    par_sum_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_q == $past(a + b)));

endmodule

// File: rtl/bit_serial_adder_top.sv
module bit_serial_adder_top #(
    parameter int unsigned WORD_W = bsa_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_a,
    input  logic              ser_b,
    input  logic              ser_start,
    output logic              ser_sum,
    input  logic [WORD_W-1:0] par_a,
    input  logic [WORD_W-1:0] par_b,
    output logic [WORD_W-1:0] par_sum
);
    import bsa_pkg::*;

    carry_sel_e carry_sel;

    bsa_slot_ctr #(.WORD_W(WORD_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .start     (ser_start),
        .carry_sel (carry_sel)
    );

    bsa_serial_core u_serial (
        .clk       (clk),
        .rst       (rst),
        .a         (ser_a),
        .b         (ser_b),
        .carry_sel (carry_sel),
        .sum_q     (ser_sum)
    );

    bsa_unfolded #(.WORD_W(WORD_W)) u_par (
        .clk   (clk),
        .rst   (rst),
        .a     (par_a),
        .b     (par_b),
        .sum_q (par_sum)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ser_sum == 1'b0 && par_sum == '0));

    // R4
    start_zero_carry_chk: assert property (@(posedge clk) disable iff (rst)
        ser_start |=> (ser_sum == $past(ser_a ^ ser_b)));

endmodule

// File: tb/bit_serial_adder_top_bench.sv
module bit_serial_adder_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_a = 1'b0, ser_b = 1'b0, ser_start = 1'b0;
    logic ser_sum;
    logic [W-1:0] par_a = '0, par_b = '0;
    logic [W-1:0] par_sum;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_serial_adder_top #(.WORD_W(W)) u_bit_serial_adder_top (
        .clk(clk), .rst(rst),
        .ser_a(ser_a), .ser_b(ser_b), .ser_start(ser_start), .ser_sum(ser_sum),
        .par_a(par_a), .par_b(par_b), .par_sum(par_sum)
    );

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] full;
        full = {1'b0, x} + {1'b0, y};
        return full[W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; sends one word serially (and in parallel), returns at a negedge.
    task automatic send_word(input logic [W-1:0] x, input logic [W-1:0] y, input bit mark);
        logic [W-1:0] got;
        logic carry;
        got = '0;
        carry = 1'b0;
        for (int k = 0; k < W; k++) begin
            ser_a = x[k];
            ser_b = y[k];
            ser_start = (k == 0) ? mark : 1'b0;
            if (k == 0) begin
                par_a = x;
                par_b = y;
            end
            @(posedge clk);
            @(negedge clk);
            got[k] = ser_sum;
            // R2 / R8: bit k arrives k+1 clocks after bit 0 and is a^b^carry
            check(ser_sum == (x[k] ^ y[k] ^ carry), "R2/R8 serial bit",
                  int'(ser_sum), int'(x[k] ^ y[k] ^ carry));
            carry = (x[k] & y[k]) | (carry & (x[k] ^ y[k]));
            if (k == 0)
                check(par_sum == ref_sum(x, y), "R6 parallel sum",
                      int'(par_sum), int'(ref_sum(x, y)));
        end
        ser_start = 1'b0;
        check(got == ref_sum(x, y), "R3 serial word", int'(got), int'(ref_sum(x, y)));
        check(got == par_sum, "R7 serial vs parallel", int'(got), int'(par_sum));
    endtask

    task automatic send_partial(input logic [W-1:0] x, input logic [W-1:0] y, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            ser_a = x[k];
            ser_b = y[k];
            ser_start = (k == 0);
            @(posedge clk);
            @(negedge clk);
        end
        ser_start = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared during reset
        check(ser_sum == 1'b0, "R1 ser_sum in reset", int'(ser_sum), 0);
        check(par_sum == '0, "R1 par_sum in reset", int'(par_sum), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(ser_sum == 1'b0, "R1 ser_sum after reset", int'(ser_sum), 0);
        check(par_sum == '0, "R1 par_sum after reset", int'(par_sum), 0);

        // R3: carry left by previous word must not leak
        send_word(4'd15, 4'd15, 1'b1);
        send_word(4'd0, 4'd0, 1'b1);
        send_word(4'd15, 4'd1, 1'b1);
        send_word(4'd8, 4'd8, 1'b1);
        send_word(4'd7, 4'd9, 1'b1);
        send_word(4'd5, 4'd10, 1'b1);

        // R4: abort mid-word with carry pending, restart
        send_partial(4'd15, 4'd1, 2);
        send_word(4'd3, 4'd4, 1'b1);
        send_partial(4'd15, 4'd15, 3);
        send_word(4'd0, 4'd1, 1'b1);

        // R5: back-to-back words with no marker after the first
        send_word(4'd5, 4'd6, 1'b1);
        send_word(4'd9, 4'd9, 1'b0);
        send_word(4'd15, 4'd15, 1'b0);
        send_word(4'd0, 4'd0, 1'b0);

        // Random pairs, markers mostly omitted (R5, R7)
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            send_word(x, y, ($urandom % 4) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule